// File: doc/BRIEF.md
# SIMD Register Move Unit

This block carries out the move instructions of a packed-integer extension. It owns a file of eight 64-bit SIMD registers and moves data between that file, the integer register file and memory. Each move is selected by the opcode byte that follows the two-byte escape and by the mode field of the operand byte. The unit zero-fills the upper half when a 32-bit value enters a SIMD register. It sends only the lower half when a SIMD register is the source of a 32-bit move. It also screens each instruction for faults before anything is written.

An instruction is offered with `op_valid_i` and taken in any cycle where `op_ready_o` is high. In that same cycle, the integer register write, the memory request (with its write-enable) and the fault report are all driven combinationally. The SIMD register write lands at the clock edge that ends the cycle. For a memory load, the loaded data is supplied together with the instruction. Address generation and the memory system are outside this block. A side read port (`peek_idx_i`/`peek_data_o`) exposes any SIMD register. No move changes any status flag, so the block has no flag outputs.

Top module: `simd_move_unit`

## Requirements
- R1: Opcode 8'h6E with mode 2'b11 writes {32'h0, int_rdata_i} into SIMD register `reg_i`.
- R2: Opcode 8'h6E with any other mode asserts mem_req_o with mem_we_o=0 and mem_wide_o=0. It writes {32'h0, ld_data_i[31:0]} into SIMD register `reg_i`. Bits 63..32 of ld_data_i have no effect.
- R3: Opcode 8'h7E with mode 2'b11 asserts int_we_o with int_widx_o=`rm_i` and int_wdata_o = bits 31..0 of SIMD register `reg_i`. No SIMD register changes.
- R4: Opcode 8'h7E with a memory mode asserts mem_req_o and mem_we_o with mem_wide_o=0 and mem_wdata_o = {32'h0, bits 31..0 of SIMD register `reg_i`}. No SIMD register changes.
- R5: Opcode 8'h6F copies SIMD register `rm_i` into SIMD register `reg_i` for mode 2'b11. For a memory mode, it asserts mem_req_o with mem_we_o=0 and mem_wide_o=1, and writes ld_data_i into SIMD register `reg_i`.
- R6: Opcode 8'h7F copies SIMD register `reg_i` into SIMD register `rm_i` for mode 2'b11. For a memory mode, it asserts mem_req_o and mem_we_o with mem_wide_o=1 and mem_wdata_o = SIMD register `reg_i`.
- R7: Any opcode byte other than 8'h6E, 8'h6F, 8'h7E and 8'h7F is rejected with fault code 1 (undefined opcode).
- R8: Fault codes are 1 for ctl_em_i=1, 2 for ctl_ts_i=1 and 3 for fp_pend_i=1. The lowest code wins when several apply. An undefined opcode ranks with code 1. On any fault, flt_valid_o=1 and there is no integer write, no memory request and no SIMD register change.
- R9: After reset, all SIMD registers read zero, op_ready_o is 1, and no write, request or fault is driven.
- R10: With op_valid_i=0, no integer write, memory request or fault report occurs, and no SIMD register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Instruction offered |
| op_ready_o | output | 1 | Unit can take an instruction |
| opc_i | input | 8 | Opcode byte after the escape byte |
| mod_i | input | 2 | Operand-byte mode field; 2'b11 = register operand |
| reg_i | input | 3 | SIMD register from the operand byte's reg field |
| rm_i | input | 3 | Register from the rm field (SIMD or integer) |
| int_rdata_i | input | 32 | Integer register value for the rm field |
| ld_data_i | input | 64 | Memory load data for this instruction |
| ctl_em_i | input | 1 | Emulation control bit |
| ctl_ts_i | input | 1 | Task-switched control bit |
| fp_pend_i | input | 1 | Floating-point fault pending |
| int_we_o | output | 1 | Integer register write enable |
| int_widx_o | output | 3 | Integer register write index |
| int_wdata_o | output | 32 | Integer register write data |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | Memory request is a store |
| mem_wide_o | output | 1 | Access size: 1 = 64 bits, 0 = 32 bits |
| mem_wdata_o | output | 64 | Store data |
| flt_valid_o | output | 1 | Instruction faulted |
| flt_code_o | output | 2 | Fault code (1 undefined, 2 not available, 3 fp pending) |
| peek_idx_i | input | 3 | SIMD register to observe |
| peek_data_o | output | 64 | Contents of the observed SIMD register |

## Verification
A corrupted SIMD register entry stays hidden until a later move reads it. It then shows up on int_wdata_o or mem_wdata_o, or when a register-to-register copy carries it forward. To close that gap, the bench reads both named registers through the peek port right after every instruction, so a wrong write shows up one clock edge after the cycle it was taken. A wrong decode or wrong fault ranking shows up in the same cycle, on the write enables, the request strobe or the fault code.

// File: rtl/simd_mv_pkg.sv
package simd_mv_pkg;
  localparam int unsigned NREG_DEF   = 8;
  localparam int unsigned DATA_W_DEF = 64;

  localparam logic [7:0] OPC_LD32 = 8'h6E;
  localparam logic [7:0] OPC_ST32 = 8'h7E;
  localparam logic [7:0] OPC_LD64 = 8'h6F;
  localparam logic [7:0] OPC_ST64 = 8'h7F;
  localparam logic [1:0] MOD_REG  = 2'b11;

  typedef enum logic [2:0] {
    MV_LD32,
    MV_ST32,
    MV_LD64,
    MV_ST64,
    MV_BAD
  } mv_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_NM   = 2'd2,
    FLT_MF   = 2'd3
  } flt_code_e;

  typedef struct packed {
    mv_kind_e kind;
    logic     known;
    logic     wide;
    logic     rm_reg;
  } mv_ctl_t;
endpackage

// File: rtl/simd_mv_decode.sv
module simd_mv_decode
  import simd_mv_pkg::*;
(
  input  logic [7:0] opc,
  input  logic [1:0] mode,
  output mv_ctl_t    ctl
);
  always_comb begin
    ctl.rm_reg = (mode == MOD_REG);
    unique case (opc)
      OPC_LD32: begin ctl.kind = MV_LD32; ctl.known = 1'b1; ctl.wide = 1'b0; end
      OPC_ST32: begin ctl.kind = MV_ST32; ctl.known = 1'b1; ctl.wide = 1'b0; end
      OPC_LD64: begin ctl.kind = MV_LD64; ctl.known = 1'b1; ctl.wide = 1'b1; end
      OPC_ST64: begin ctl.kind = MV_ST64; ctl.known = 1'b1; ctl.wide = 1'b1; end
      default:  begin ctl.kind = MV_BAD;  ctl.known = 1'b0; ctl.wide = 1'b0; end
    endcase
  end
endmodule

// File: rtl/simd_mv_fault.sv
module simd_mv_fault
  import simd_mv_pkg::*;
(
  input  logic      known,
  input  logic      em,
  input  logic      ts,
  input  logic      fp,
  output flt_code_e code
);
  always_comb begin
    if (em || !known)  code = FLT_UD;
    else if (ts)       code = FLT_NM;
    else if (fp)       code = FLT_MF;
    else               code = FLT_NONE;
  end
endmodule

// File: rtl/simd_mv_rf.sv
module simd_mv_rf #(
  parameter int unsigned NREG     = 8,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned RD_PORTS = 3,
  localparam int unsigned IDX_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx  [RD_PORTS],
  output logic [DATA_W-1:0] rdata [RD_PORTS]
);
  logic [DATA_W-1:0] ent_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic              ent_en;
    logic [DATA_W-1:0] ent_d;

    always_comb begin
      ent_en = we && (widx == IDX_W'(g));
      ent_d  = ent_en ? wdata : ent_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= ent_d;
    end
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    assign rdata[r] = ent_q[ridx[r]];
  end
endmodule

// File: rtl/simd_move_unit.sv
module simd_move_unit
  import simd_mv_pkg::*;
#(
  parameter int unsigned NREG   = NREG_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic [7:0]        opc_i,
  input  logic [1:0]        mod_i,
  input  logic [IDX_W-1:0]  reg_i,
  input  logic [IDX_W-1:0]  rm_i,
  input  logic [HALF_W-1:0] int_rdata_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              ctl_em_i,
  input  logic              ctl_ts_i,
  input  logic              fp_pend_i,
  output logic              int_we_o,
  output logic [IDX_W-1:0]  int_widx_o,
  output logic [HALF_W-1:0] int_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_wide_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              flt_valid_o,
  output logic [1:0]        flt_code_o,
  input  logic [IDX_W-1:0]  peek_idx_i,
  output logic [DATA_W-1:0] peek_data_o
);
  localparam int unsigned PORT_A = 0;
  localparam int unsigned PORT_B = 1;
  localparam int unsigned PORT_P = 2;

  logic              rdy_q, rdy_d;
  mv_ctl_t           ctl;
  flt_code_e         code;
  logic              take, go;
  logic              rf_we;
  logic [IDX_W-1:0]  rf_widx;
  logic [DATA_W-1:0] rf_wdata;
  logic [IDX_W-1:0]  rf_ridx  [3];
  logic [DATA_W-1:0] rf_rdata [3];
  logic [DATA_W-1:0] src_a, src_b;

  always_comb rdy_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  simd_mv_decode u_dec (
    .opc  (opc_i),
    .mode (mod_i),
    .ctl  (ctl)
  );

  simd_mv_fault u_flt (
    .known (ctl.known),
    .em    (ctl_em_i),
    .ts    (ctl_ts_i),
    .fp    (fp_pend_i),
    .code  (code)
  );

  always_comb begin
    rf_ridx[PORT_A] = reg_i;
    rf_ridx[PORT_B] = rm_i;
    rf_ridx[PORT_P] = peek_idx_i;
  end

  simd_mv_rf #(
    .NREG     (NREG),
    .DATA_W   (DATA_W),
    .RD_PORTS (3)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .widx  (rf_widx),
    .wdata (rf_wdata),
    .ridx  (rf_ridx),
    .rdata (rf_rdata)
  );

  assign src_a       = rf_rdata[PORT_A];
  assign src_b       = rf_rdata[PORT_B];
  assign peek_data_o = rf_rdata[PORT_P];
  assign op_ready_o  = rdy_q;

  always_comb begin
    take = op_valid_i && rdy_q;
    go   = take && (code == FLT_NONE);

    flt_valid_o = take && (code != FLT_NONE);
    flt_code_o  = flt_valid_o ? code : FLT_NONE;

    rf_we    = 1'b0;
    rf_widx  = reg_i;
    rf_wdata = '0;
    int_we_o    = 1'b0;
    int_widx_o  = rm_i;
    int_wdata_o = src_a[HALF_W-1:0];
    mem_req_o   = go && !ctl.rm_reg;
    mem_we_o    = 1'b0;
    mem_wide_o  = ctl.wide;
    mem_wdata_o = ctl.wide ? src_a : {{HALF_W{1'b0}}, src_a[HALF_W-1:0]};

    unique case (ctl.kind)
      MV_LD32: begin
        rf_we    = go;
        rf_wdata = {{HALF_W{1'b0}},
                    ctl.rm_reg ? int_rdata_i : ld_data_i[HALF_W-1:0]};
      end
      MV_LD64: begin
        rf_we    = go;
        rf_wdata = ctl.rm_reg ? src_b : ld_data_i;
      end
      MV_ST32: begin
        int_we_o = go && ctl.rm_reg;
        mem_we_o = go && !ctl.rm_reg;
      end
      MV_ST64: begin
        rf_we    = go && ctl.rm_reg;
        rf_widx  = rm_i;
        rf_wdata = src_a;
        mem_we_o = go && !ctl.rm_reg;
      end
      default: begin
        rf_we = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/simd_mv_chk.sv
module simd_mv_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid_i,
  input logic [7:0]        opc_i,
  input logic [1:0]        mod_i,
  input logic              ctl_em_i,
  input logic              int_we_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              flt_valid_o,
  input logic [1:0]        flt_code_o,
  input logic              op_ready_o,
  input logic              rf_we,
  input logic [DATA_W-1:0] rf_wdata
);
  localparam int unsigned HALF_W = DATA_W / 2;

  a_r8_fault_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid_o |-> (!int_we_o && !mem_req_o && !rf_we));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |-> (!int_we_o && !mem_req_o && !flt_valid_o && !rf_we));

  a_r4_store_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o);

  a_r8_em_first: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_ready_o && ctl_em_i) |-> (flt_valid_o && flt_code_o == 2'd1));

  a_r1_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && opc_i == 8'h6E) |-> (rf_wdata[DATA_W-1:HALF_W] == '0));

  a_r3_int_write_form: assert property (@(posedge clk) disable iff (!rst_n)
    int_we_o |-> (opc_i == 8'h7E && mod_i == 2'b11));

  a_r9_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready_o |=> op_ready_o);
endmodule

bind simd_move_unit simd_mv_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid_i  (op_valid_i),
  .opc_i       (opc_i),
  .mod_i       (mod_i),
  .ctl_em_i    (ctl_em_i),
  .int_we_o    (int_we_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .flt_valid_o (flt_valid_o),
  .flt_code_o  (flt_code_o),
  .op_ready_o  (op_ready_o),
  .rf_we       (rf_we),
  .rf_wdata    (rf_wdata)
);

// File: tb/test_simd_move_unit.sv
module test_simd_move_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        op_valid_i, op_ready_o;
  logic [7:0]  opc_i;
  logic [1:0]  mod_i;
  logic [2:0]  reg_i, rm_i;
  logic [31:0] int_rdata_i;
  logic [63:0] ld_data_i;
  logic        ctl_em_i, ctl_ts_i, fp_pend_i;
  logic        int_we_o;
  logic [2:0]  int_widx_o;
  logic [31:0] int_wdata_o;
  logic        mem_req_o, mem_we_o, mem_wide_o;
  logic [63:0] mem_wdata_o;
  logic        flt_valid_o;
  logic [1:0]  flt_code_o;
  logic [2:0]  peek_idx_i;
  logic [63:0] peek_data_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [8];

  simd_move_unit i_simd_move_unit (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_ready_o(op_ready_o),
    .opc_i(opc_i), .mod_i(mod_i), .reg_i(reg_i), .rm_i(rm_i),
    .int_rdata_i(int_rdata_i), .ld_data_i(ld_data_i),
    .ctl_em_i(ctl_em_i), .ctl_ts_i(ctl_ts_i), .fp_pend_i(fp_pend_i),
    .int_we_o(int_we_o), .int_widx_o(int_widx_o), .int_wdata_o(int_wdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_wide_o(mem_wide_o),
    .mem_wdata_o(mem_wdata_o), .flt_valid_o(flt_valid_o), .flt_code_o(flt_code_o),
    .peek_idx_i(peek_idx_i), .peek_data_o(peek_data_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input logic [7:0] opc, input bit em,
                                          input bit ts, input bit fp);
    bit known = (opc == 8'h6E) || (opc == 8'h6F) || (opc == 8'h7E) || (opc == 8'h7F);
    if (em || !known) return 2'd1;
    if (ts) return 2'd2;
    if (fp) return 2'd3;
    return 2'd0;
  endfunction

  task automatic peek_chk(input logic [2:0] idx, input string req);
    peek_idx_i = idx;
    #1;
    chk(peek_data_o === model[idx], req, "simd reg", peek_data_o, model[idx]);
  endtask

  task automatic run_op(input logic [7:0] opc, input logic [1:0] md,
                        input logic [2:0] rg, input logic [2:0] rm,
                        input logic [31:0] iv, input logic [63:0] ld,
                        input bit em, input bit ts, input bit fp);
    logic [1:0]  ecode;
    bit          isreg, e_int, e_req, e_we, e_wide, e_rf;
    logic [2:0]  e_ridx;
    logic [63:0] e_rdat, e_wdat;
    string       req;
    @(negedge clk);
    opc_i = opc; mod_i = md; reg_i = rg; rm_i = rm;
    int_rdata_i = iv; ld_data_i = ld;
    ctl_em_i = em; ctl_ts_i = ts; fp_pend_i = fp;
    op_valid_i = 1'b1;
    #1;
    ecode = exp_code(opc, em, ts, fp);
    isreg = (md == 2'b11);
    e_int = 0; e_req = 0; e_we = 0; e_wide = 0; e_rf = 0;
    e_ridx = rg; e_rdat = '0; e_wdat = '0;
    if (ecode != 0) req = (opc == 8'h6E || opc == 8'h6F || opc == 8'h7E || opc == 8'h7F) ? "R8" : "R7";
    else begin
      case (opc)
        8'h6E: begin
          req = isreg ? "R1" : "R2";
          e_rf = 1; e_rdat = {32'h0, isreg ? iv : ld[31:0]}; e_req = !isreg;
        end
        8'h7E: begin
          req = isreg ? "R3" : "R4";
          e_int = isreg; e_req = !isreg; e_we = !isreg; e_wdat = {32'h0, model[rg][31:0]};
        end
        8'h6F: begin
          req = "R5";
          e_rf = 1; e_rdat = isreg ? model[rm] : ld; e_req = !isreg; e_wide = 1;
        end
        default: begin
          req = "R6";
          e_rf = isreg; e_ridx = rm; e_rdat = model[rg];
          e_req = !isreg; e_we = !isreg; e_wide = 1; e_wdat = model[rg];
        end
      endcase
    end
    chk(flt_valid_o === (ecode != 0), req, "flt_valid", 64'(flt_valid_o), 64'(ecode != 0));
    if (ecode != 0) chk(flt_code_o === ecode, req, "flt_code", 64'(flt_code_o), 64'(ecode));
    chk(int_we_o === e_int, req, "int_we", 64'(int_we_o), 64'(e_int));
    if (e_int) begin
      chk(int_widx_o === rm, req, "int_widx", 64'(int_widx_o), 64'(rm));
      chk(int_wdata_o === model[rg][31:0], req, "int_wdata", 64'(int_wdata_o), 64'(model[rg][31:0]));
    end
    chk(mem_req_o === e_req, req, "mem_req", 64'(mem_req_o), 64'(e_req));
    chk(mem_we_o === e_we, req, "mem_we", 64'(mem_we_o), 64'(e_we));
    if (e_req) chk(mem_wide_o === e_wide, req, "mem_wide", 64'(mem_wide_o), 64'(e_wide));
    if (e_we) chk(mem_wdata_o === e_wdat, req, "mem_wdata", mem_wdata_o, e_wdat);
    @(posedge clk);
    if (e_rf) model[e_ridx] = e_rdat;
    #1;
    op_valid_i = 1'b0;
    peek_chk(rg, req);
    peek_chk(rm, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_valid_i = 1'b0; opc_i = 8'h0; mod_i = 2'b0; reg_i = 3'd0; rm_i = 3'd0;
    int_rdata_i = '0; ld_data_i = '0; ctl_em_i = 0; ctl_ts_i = 0; fp_pend_i = 0; peek_idx_i = 3'd0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: reset state
    chk(op_ready_o === 1'b1, "R9", "ready", 64'(op_ready_o), 64'd1);
    chk(!int_we_o && !mem_req_o && !flt_valid_o, "R9", "idle outputs",
        64'({int_we_o, mem_req_o, flt_valid_o}), 64'd0);
    for (int i = 0; i < 8; i++) peek_chk(3'(i), "R9");

    // Directed corner cases
    run_op(8'h6E, 2'b00, 3'd1, 3'd0, 32'h0, 64'hFFFF_FFFF_1234_5678, 0, 0, 0); // R2 upper ignored
    run_op(8'h6E, 2'b11, 3'd2, 3'd5, 32'hDEAD_BEEF, 64'h0, 0, 0, 0);          // R1
    run_op(8'h6F, 2'b10, 3'd3, 3'd0, 32'h0, 64'hA5A5_0102_0304_5A5A, 0, 0, 0); // R5 mem
    run_op(8'h6F, 2'b11, 3'd4, 3'd3, 32'h0, 64'h0, 0, 0, 0);                  // R5 reg
    run_op(8'h7E, 2'b11, 3'd3, 3'd6, 32'h0, 64'h0, 0, 0, 0);                  // R3
    run_op(8'h7E, 2'b01, 3'd3, 3'd0, 32'h0, 64'h0, 0, 0, 0);                  // R4
    run_op(8'h7F, 2'b11, 3'd3, 3'd7, 32'h0, 64'h0, 0, 0, 0);                  // R6 reg
    run_op(8'h7F, 2'b00, 3'd7, 3'd0, 32'h0, 64'h0, 0, 0, 0);                  // R6 mem
    run_op(8'h63, 2'b11, 3'd0, 3'd3, 32'h1, 64'h0, 0, 0, 0);                  // R7
    run_op(8'h6F, 2'b00, 3'd3, 3'd0, 32'h0, 64'h1111, 1, 1, 1);               // R8 code 1
    run_op(8'h6F, 2'b00, 3'd3, 3'd0, 32'h0, 64'h2222, 0, 1, 1);               // R8 code 2
    run_op(8'h7E, 2'b11, 3'd3, 3'd1, 32'h0, 64'h0, 0, 0, 1);                  // R8 code 3
    run_op(8'h5A, 2'b00, 3'd3, 3'd0, 32'h0, 64'h0, 0, 1, 0);                  // R7 over ts

    // R10: instruction present but not valid
    @(negedge clk);
    opc_i = 8'h6E; mod_i = 2'b11; reg_i = 3'd3; rm_i = 3'd0; int_rdata_i = 32'hCAFE_F00D;
    op_valid_i = 1'b0; #1;
    chk(!int_we_o && !mem_req_o && !flt_valid_o, "R10", "idle outputs",
        64'({int_we_o, mem_req_o, flt_valid_o}), 64'd0);
    @(posedge clk); #1;
    peek_chk(3'd3, "R10");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] opc;
      int sel = $urandom % 10;
      case (sel)
        0, 1: opc = 8'h6E;
        2, 3: opc = 8'h6F;
        4, 5: opc = 8'h7E;
        6, 7: opc = 8'h7F;
        default: opc = 8'($urandom);
      endcase
      run_op(opc, 2'($urandom), 3'($urandom), 3'($urandom), $urandom,
             {$urandom, $urandom}, ($urandom % 16) == 0, ($urandom % 12) == 0,
             ($urandom % 10) == 0);
    end

    for (int i = 0; i < 8; i++) peek_chk(3'(i), "R5");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule